// File: doc/BRIEF.md
# Reload-Controlled Programmable Clock Divider

This block derives a slower clock from a single reference clock by integer division. Software reaches it through a small register port with address, write strobe, write data and combinational read data. The port holds two words: a control word and a ratio word. A new ratio is first written into the ratio word, where it only waits. The running divider changes to it only after a reload sequence.

The control word carries three things. Low bits ask for a reload of one output. A global bit fires the reload. A bit in the upper byte enables the output. Once a reload has been taken, software clears the request bits, and the divider keeps the ratio it loaded. The output never shows a shortened pulse. A ratio change waits for the end of the current period, and a disable waits until the output is low. Only four ratios are accepted. Any other staged code is dropped when the reload fires.

Top module: `ratio_clkdiv`

## Requirements
- R1: After reset the output is low, the control word reads 0x00000000 and the ratio word reads 0x00000800 (staged ratio 8). The running ratio is also 8.
- R2: The control word is at address 0x0 and the ratio word at address 0x8. The ratio occupies bits [13:8] of the ratio word, and a read returns the staged field with all other bits zero. Any other address reads zero and ignores writes.
- R3: Writing the ratio field alone does not change the period of the running output.
- R4: A staged ratio is loaded only while control bit 1 (reload request for output 1) and control bit 8 (reload fire) are both set. Either bit alone has no effect.
- R5: After bits [8:0] of the control word are cleared, the output keeps running at the ratio last loaded.
- R6: With running ratio r in {4,5,6,8}, the output period is r reference cycles. The output is high for floor(r/2) cycles and low for the rest.
- R7: On reload, a staged code outside {4,5,6,8} is ignored and the previous running ratio is kept.
- R8: Control bit 25 enables the output. While it is clear, the output is held low. Once it is set, the output toggles.
- R9: Clearing the enable in the middle of a high phase lets that high phase finish at full length. After that the output stays low.
- R10: A newly loaded ratio takes effect only at the start of a new period. The period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| div_clk_o | output | 1 | Divided clock output |

## Verification
The bench builds the block with its default parameters: a 6-bit ratio field and one output at index 1. With only 64 codes, the field can be swept completely. Every code is staged and reloaded in turn, and the measured period is checked against either the code itself or the ratio that was already running. Each legal ratio is also measured for both its high and low phase lengths. Directed cases cover a disable during a high phase and a reload fired during a period.

// File: rtl/ratio_clkdiv.sv
module ratio_clkdiv #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int CTRL_ADDR   = 0,
  parameter int RATIO_ADDR  = 8,
  parameter int OUT_IDX     = 1,
  parameter int TRIG_BIT    = 8,
  parameter int EN_BASE     = 24,
  parameter int RATIO_LSB   = 8,
  parameter int RATIO_W     = 6,
  parameter int RESET_RATIO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              div_clk_o
);

  localparam int EN_BIT = EN_BASE + OUT_IDX;
  localparam int RATIO_MSB = RATIO_LSB + RATIO_W - 1;
  localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(RATIO_ADDR);

  function automatic logic ratio_ok(input logic [RATIO_W-1:0] r);
    return (r == RATIO_W'(4)) || (r == RATIO_W'(5)) ||
           (r == RATIO_W'(6)) || (r == RATIO_W'(8));
  endfunction

  logic [DATA_W-1:0]  ctrl_q;
  logic [RATIO_W-1:0] stage_q, cur_q, pend_q, cnt_q;
  logic               pend_v_q, run_q, clk_q;

  logic [RATIO_W-1:0] cur_d, cnt_d;
  logic               run_d, clk_d;

  wire wr_ctrl    = reg_we && (reg_addr == A_CTRL);
  wire wr_ratio   = reg_we && (reg_addr == A_RATIO);
  wire reload_req = ctrl_q[TRIG_BIT] && ctrl_q[OUT_IDX] && ratio_ok(stage_q);
  wire enable     = ctrl_q[EN_BIT];
  wire boundary   = !run_q || (cnt_q == cur_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      stage_q <= RST_RATIO;
    end else begin
      if (wr_ctrl)  ctrl_q  <= reg_wdata;
      if (wr_ratio) stage_q <= reg_wdata[RATIO_MSB:RATIO_LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= RST_RATIO;
      pend_v_q <= 1'b0;
    end else if (reload_req) begin
      pend_q   <= stage_q;
      pend_v_q <= 1'b1;
    end else if (boundary) begin
      pend_v_q <= 1'b0;
    end
  end

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q + 1'b1;
    run_d = run_q;
    if (boundary) begin
      run_d = enable;
      cnt_d = '0;
      if (pend_v_q) cur_d = pend_q;
    end
    clk_d = run_d && (cnt_d < (cur_d >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= RST_RATIO;
      cnt_q <= '0;
      run_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
      run_q <= run_d;
      clk_q <= clk_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) reg_rdata = ctrl_q;
    else if (reg_addr == A_RATIO) reg_rdata[RATIO_MSB:RATIO_LSB] = stage_q;
  end

  assign div_clk_o = clk_q;

endmodule

// File: rtl/ratio_clkdiv_chk.sv
module ratio_clkdiv_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int RATIO_ADDR = 8,
  parameter int RATIO_LSB  = 8,
  parameter int RATIO_W    = 6,
  parameter int EN_BIT     = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_we,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               div_clk_o,
  input logic [DATA_W-1:0]  ctrl_q,
  input logic [RATIO_W-1:0] stage_q,
  input logic [RATIO_W-1:0] cur_q,
  input logic [RATIO_W-1:0] cnt_q
);

  logic [7:0] hi_len, lo_len, off_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= '0;
      lo_len  <= '0;
      off_len <= '0;
    end else begin
      hi_len  <= div_clk_o ? ((hi_len == 8'hff) ? hi_len : hi_len + 1'b1) : 8'd0;
      lo_len  <= !div_clk_o ? ((lo_len == 8'hff) ? lo_len : lo_len + 1'b1) : 8'd0;
      off_len <= !ctrl_q[EN_BIT] ? ((off_len == 8'hff) ? off_len : off_len + 1'b1) : 8'd0;
    end
  end

  p_high_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_clk_o) |-> (hi_len == 8'(cur_q >> 1)));

  p_low_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_clk_o) |-> (lo_len >= 8'd2));

  p_ratio_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q == 6'd4) || (cur_q == 6'd5) || (cur_q == 6'd6) || (cur_q == 6'd8));

  p_apply_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> (cnt_q == '0));

  p_stage_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == ADDR_W'(RATIO_ADDR))) |=>
      (stage_q == $past(reg_wdata[RATIO_LSB+RATIO_W-1:RATIO_LSB])));

  p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (off_len >= 8'd10) |-> !div_clk_o);

endmodule

bind ratio_clkdiv ratio_clkdiv_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_ADDR(RATIO_ADDR),
  .RATIO_LSB(RATIO_LSB), .RATIO_W(RATIO_W), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .div_clk_o(div_clk_o), .ctrl_q(ctrl_q),
  .stage_q(stage_q), .cur_q(cur_q), .cnt_q(cnt_q)
);

// File: tb/test_ratio_clkdiv.sv
module test_ratio_clkdiv;
  localparam logic [31:0] EN   = 32'h0200_0000;
  localparam logic [31:0] REQ  = 32'h0000_0002;
  localparam logic [31:0] FIRE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        div_clk_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ratio_clkdiv i_ratio_clkdiv (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_clk_o(div_clk_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    int t = 0;
    hi = 0; lo = 0;
    while (div_clk_o === 1'b1 && t < 64) begin @(negedge clk); t++; end
    while (div_clk_o === 1'b0 && t < 64) begin @(negedge clk); t++; end
    while (div_clk_o === 1'b1 && t < 128) begin hi++; @(negedge clk); t++; end
    while (div_clk_o === 1'b0 && t < 128) begin lo++; @(negedge clk); t++; end
  endtask

  task automatic load(input int r);
    wr(4'h8, 32'(r) << 8);
    wr(4'h0, EN | REQ);
    wr(4'h0, EN | REQ | FIRE);
    idle(20);
    wr(4'h0, EN);
    idle(20);
  endtask

  task automatic period_chk(input int r, input string req);
    int hi, lo;
    measure(hi, lo);
    chk(hi == r / 2, req, hi, r / 2);
    chk(lo == r - r / 2, req, lo, r - r / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int highs, hi, lo, expr;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    highs = 0;
    for (int i = 0; i < 20; i++) begin highs += div_clk_o; @(negedge clk); end
    chk(highs == 0, "R1 output low", highs, 0);
    rd_chk(4'h0, 32'h0, "R1 ctrl reset");
    rd_chk(4'h8, 32'h800, "R1 ratio reset");

    // R8 enable starts output at default ratio
    wr(4'h0, EN);
    period_chk(8, "R8 R6 default ratio");

    // R3 staging alone leaves period
    wr(4'h8, 32'h400);
    rd_chk(4'h8, 32'h400, "R2 staged readback");
    idle(20);
    period_chk(8, "R3 staged only");

    // R4 request or fire alone
    wr(4'h0, EN | REQ); idle(20);
    period_chk(8, "R4 request only");
    wr(4'h0, EN | FIRE); idle(20);
    period_chk(8, "R4 fire only");
    wr(4'h0, EN); idle(20);

    // R2 address decode
    wr(4'h4, 32'hFFFF_FFFF);
    rd_chk(4'h4, 32'h0, "R2 unmapped read");
    rd_chk(4'h0, EN, "R2 ctrl untouched");
    rd_chk(4'h8, 32'h400, "R2 ratio untouched");
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk(4'h8, 32'h3F00, "R2 ratio field mask");

    // R6 R5 each legal ratio, request bits cleared
    for (int k = 0; k < 4; k++) begin
      int r = (k == 3) ? 8 : 4 + k;
      load(r);
      rd_chk(4'h0, EN, "R5 request bits cleared");
      period_chk(r, "R5 R6 legal ratio");
    end

    // R7 sweep over every code of the ratio field
    load(5);
    expr = 5;
    for (int c = 0; c < 64; c++) begin
      load(c);
      if (c == 4 || c == 5 || c == 6 || c == 8) expr = c;
      period_chk(expr, "R7 code sweep");
    end

    // R10 reload fired during a period of ratio 8
    load(8);
    wr(4'h8, 32'h400);
    while (div_clk_o !== 1'b0) @(negedge clk);
    while (div_clk_o !== 1'b1) @(negedge clk);
    hi = 1;
    wr(4'h0, EN | REQ | FIRE);
    while (div_clk_o === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
    lo = 0;
    while (div_clk_o === 1'b0 && lo < 40) begin lo++; @(negedge clk); end
    chk(hi == 4, "R10 old high kept", hi, 4);
    chk(lo == 4, "R10 old low kept", lo, 4);
    period_chk(4, "R10 new ratio");
    wr(4'h0, EN); idle(10);

    // R9 disable during a high phase with ratio 6
    load(6);
    while (div_clk_o !== 1'b0) @(negedge clk);
    while (div_clk_o !== 1'b1) @(negedge clk);
    hi = 1;
    wr(4'h0, 32'h0);
    while (div_clk_o === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
    chk(hi == 3, "R9 full high on disable", hi, 3);
    highs = 0;
    for (int i = 0; i < 40; i++) begin highs += div_clk_o; @(negedge clk); end
    chk(highs == 0, "R9 R8 held low", highs, 0);
    wr(4'h0, EN);
    period_chk(6, "R8 restart");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule